// File: doc/BRIEF.md
# Watchdog Timer with Two-Step Clear

This block is the watchdog of a small microcontroller. It runs from a free-running watchdog clock. A 6-bit prescaler counts every cycle, and a selectable prescaler bit sets the tick rate. The ticks then drive a single clearable final stage. When the final stage wraps, the watchdog times out. The time-out sets a status flag and sends out a one-cycle pulse. That pulse goes to the reset logic when the processor is running, and to the wake-up logic when it is halted.

Software keeps the watchdog alive with two different clear strobes, A and B. A clear is accepted only when one strobe is followed by the other one. A runaway program that repeats a single clear command therefore cannot keep the watchdog quiet. An accepted clear resets only the final stage and leaves the prescaler running. The time to the next time-out therefore depends on where the prescaler stood when the clear arrived. A halt strobe clears the whole divider and the clear tracker, and it marks the power-down state in the status flags.

Top module: `wdt_dual_clear`

## Requirements
- R1: After reset, `to_flag`, `pd_flag`, `reset_pulse` and `wake_pulse` are all 0, and the clear tracker holds no pending command.
- R2: A clear completes in the cycle in which a lone strobe arrives whose other strobe was the most recent lone strobe. The order can be A then B or B then A, with any number of idle cycles in between. A completed clear drives `to_flag` and `pd_flag` to 0, resets the final stage and returns the tracker to idle.
- R3: Repeating the same strobe, with the other one not in between, completes no clear, and both flags keep their values. A cycle with `clr_a` and `clr_b` both high is ignored and leaves the tracker unchanged.
- R4: The prescaler tick comes once every P = 2^(tap+1) cycles, where tap is `tap_sel`. A `tap_sel` above 5 acts as 5. Starting from a zeroed divider, the time-out pulse is seen 2P cycles after enable is applied.
- R5: After a completed clear, the next time-out pulse is seen no sooner than P+2 and no later than 2P+1 cycles after the cycle in which the completing strobe is applied. The exact value depends on the prescaler phase, because the prescaler is not cleared.
- R6: A time-out sets `to_flag` to 1 and raises a pulse that lasts exactly one cycle. While the block is not halted, the pulse comes on `reset_pulse`.
- R7: A halt zeroes the prescaler, the final stage and the tracker, sets `pd_flag` to 1 and clears `to_flag`. If a time-out falls in the same cycle, the halt wins and no pulse is produced.
- R8: The first time-out after a halt comes on `wake_pulse` and not on `reset_pulse`. Later time-outs come on `reset_pulse` again. The two pulses are never high together.
- R9: While `enable` is low, the divider is held at zero and neither pulse is produced. The flags and the tracker still respond to strobes.
- R10: When a clear completes in the same cycle as a time-out, the clear wins: no pulse is produced and `to_flag` ends at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Watchdog run enable |
| clr_a | input | 1 | Clear command A strobe |
| clr_b | input | 1 | Clear command B strobe |
| halt | input | 1 | Power-down command strobe |
| tap_sel | input | TAP_W (3) | Prescaler bit that sets the tick period |
| reset_pulse | output | 1 | One-cycle time-out pulse while running |
| wake_pulse | output | 1 | One-cycle time-out pulse while halted |
| to_flag | output | 1 | Time-out status flag |
| pd_flag | output | 1 | Power-down status flag |

## Verification
The hardest cases to reach from the ports are a clear strobe or a halt that lands in the exact cycle of a time-out. Both need the prescaler phase to be known precisely. The stimulus gets there by first holding enable low, which zeroes the divider. Enable is then raised and the bench counts 2P-1 cycles. It then applies the completing strobe, or the halt, so that it is sampled on the overflow edge. The spread of time-out delays after a clear is reached by applying the clear at four different offsets from a known time-out. The bench checks that each delay falls inside the allowed window and that the delays are not all equal.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Clear tracker encoding: 0 idle, 1 last lone strobe was A, 2 last lone strobe was B
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_SAW_A = 2'd1,
        SEQ_SAW_B = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic stage;
        logic to_flag;
        logic pd_flag;
        logic halted;
        logic rst_pulse;
        logic wake_pulse;
    } core_regs_t;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int PRE_BITS = 6,
    parameter int TAP_W    = $clog2(PRE_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [TAP_W-1:0] tap_sel,
    output logic             tick
);

    localparam logic [TAP_W-1:0] TAP_MAX = TAP_W'(PRE_BITS - 1);

    logic [PRE_BITS-1:0] cnt_d, cnt_q;
    logic [PRE_BITS-1:0] carry;
    logic [TAP_W-1:0]    tap_eff;

    // carry[i]: bits i..0 all ones, so the next increment carries out of bit i
    for (genvar gi = 0; gi < PRE_BITS; gi++) begin : g_carry
        assign carry[gi] = &cnt_q[gi:0];
    end

    always_comb begin
        tap_eff = (tap_sel > TAP_MAX) ? TAP_MAX : tap_sel;
        tick    = run && carry[tap_eff];
        if (!run || restart) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/wdt_clear_seq.sv
module wdt_clear_seq
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_a,
    input  logic       cmd_b,
    input  logic       abort,
    output logic       done,
    output seq_state_e state_o
);

    seq_state_e state_d, state_q;
    logic       lone_a, lone_b;

    always_comb begin
        lone_a  = cmd_a && !cmd_b;
        lone_b  = cmd_b && !cmd_a;
        done    = 1'b0;
        state_d = state_q;
        if (abort) begin
            state_d = SEQ_IDLE;
        end else if (lone_a) begin
            if (state_q == SEQ_SAW_B) begin
                done    = 1'b1;
                state_d = SEQ_IDLE;
            end else begin
                state_d = SEQ_SAW_A;
            end
        end else if (lone_b) begin
            if (state_q == SEQ_SAW_A) begin
                done    = 1'b1;
                state_d = SEQ_IDLE;
            end else begin
                state_d = SEQ_SAW_B;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/wdt_dual_clear.sv
module wdt_dual_clear #(
    parameter int PRE_BITS = 6,
    parameter int TAP_W    = $clog2(PRE_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             clr_a,
    input  logic             clr_b,
    input  logic             halt,
    input  logic [TAP_W-1:0] tap_sel,
    output logic             reset_pulse,
    output logic             wake_pulse,
    output logic             to_flag,
    output logic             pd_flag
);
    import wdt_pkg::*;

    logic       tick;
    logic       clr_done;
    logic       overflow;
    seq_state_e seq_q;
    core_regs_t r_d, r_q;

    wdt_prescaler #(
        .PRE_BITS(PRE_BITS),
        .TAP_W   (TAP_W)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (enable),
        .restart(halt),
        .tap_sel(tap_sel),
        .tick   (tick)
    );

    wdt_clear_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_a  (clr_a),
        .cmd_b  (clr_b),
        .abort  (halt),
        .done   (clr_done),
        .state_o(seq_q)
    );

    always_comb begin
        r_d          = r_q;
        // halt and a completed clear both outrank a wrap of the final stage
        overflow     = tick && r_q.stage && !halt && !clr_done;
        r_d.rst_pulse  = overflow && !r_q.halted;
        r_d.wake_pulse = overflow && r_q.halted;

        if (!enable || halt || clr_done) begin
            r_d.stage = 1'b0;
        end else if (tick) begin
            r_d.stage = ~r_q.stage;
        end

        if (halt) begin
            r_d.to_flag = 1'b0;
            r_d.pd_flag = 1'b1;
            r_d.halted  = 1'b1;
        end else begin
            if (clr_done) begin
                r_d.to_flag = 1'b0;
                r_d.pd_flag = 1'b0;
            end
            if (overflow) begin
                r_d.to_flag = 1'b1;
                r_d.halted  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign reset_pulse = r_q.rst_pulse;
    assign wake_pulse  = r_q.wake_pulse;
    assign to_flag     = r_q.to_flag;
    assign pd_flag     = r_q.pd_flag;

endmodule

// File: rtl/wdt_dual_clear_chk.sv
module wdt_dual_clear_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic       clr_a,
    input logic       clr_b,
    input logic       halt,
    input logic       reset_pulse,
    input logic       wake_pulse,
    input logic       to_flag,
    input logic       pd_flag,
    input logic [1:0] seq_state
);

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(reset_pulse && wake_pulse)); // R8

    AST_PULSE_SETS_TO: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_pulse || wake_pulse) |-> to_flag); // R6

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reset_pulse |=> !reset_pulse); // R6

    AST_HALT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (pd_flag && !to_flag && !reset_pulse && !wake_pulse)); // R7

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!reset_pulse && !wake_pulse)); // R9

    AST_REPEAT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_a && !clr_b && !halt && to_flag && seq_state != 2'd2)
        |=> (to_flag && $stable(pd_flag))); // R3

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 2'd1 && clr_b && !clr_a && !halt)
        |=> (!to_flag && !pd_flag && !reset_pulse && !wake_pulse)); // R10

endmodule

bind wdt_dual_clear wdt_dual_clear_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .clr_a      (clr_a),
    .clr_b      (clr_b),
    .halt       (halt),
    .reset_pulse(reset_pulse),
    .wake_pulse (wake_pulse),
    .to_flag    (to_flag),
    .pd_flag    (pd_flag),
    .seq_state  (seq_q)
);

// File: tb/test_wdt_dual_clear.sv
module test_wdt_dual_clear;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       clr_a = 1'b0;
    logic       clr_b = 1'b0;
    logic       halt = 1'b0;
    logic [2:0] tap_sel = 3'd0;
    logic       reset_pulse, wake_pulse, to_flag, pd_flag;

    int checks = 0;
    int errors = 0;
    int rp_seen = 0;
    int wp_seen = 0;

    always #4 clk = ~clk;

    wdt_dual_clear i_wdt_dual_clear (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .clr_a      (clr_a),
        .clr_b      (clr_b),
        .halt       (halt),
        .tap_sel    (tap_sel),
        .reset_pulse(reset_pulse),
        .wake_pulse (wake_pulse),
        .to_flag    (to_flag),
        .pd_flag    (pd_flag)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Behavioural reference: phase counter, wrap count and last lone command
    int  m_phase, m_half, m_last, m_to, m_pd, m_halted, m_rp, m_wp;
    int  m_period;
    bit  m_tick, m_done, m_wrap;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_half = 0; m_last = 0; m_to = 0;
            m_pd = 0; m_halted = 0; m_rp = 0; m_wp = 0;
        end else begin
            m_period = 2 << ((tap_sel > 3'd5) ? 5 : int'(tap_sel));
            m_tick   = enable && ((m_phase % m_period) == m_period - 1);
            m_done   = !halt && ((clr_a && !clr_b && m_last == 2) ||
                                 (clr_b && !clr_a && m_last == 1));
            m_wrap   = m_tick && (m_half == 1) && !halt && !m_done;
            m_rp     = (m_wrap && m_halted == 0) ? 1 : 0;
            m_wp     = (m_wrap && m_halted == 1) ? 1 : 0;
            if (halt) begin
                m_to = 0; m_pd = 1; m_halted = 1; m_last = 0;
            end else begin
                if (m_done) begin
                    m_to = 0; m_pd = 0; m_last = 0;
                end else if (clr_a && !clr_b) begin
                    m_last = 1;
                end else if (clr_b && !clr_a) begin
                    m_last = 2;
                end
                if (m_wrap) begin
                    m_to = 1; m_halted = 0;
                end
            end
            if (!enable || halt || m_done) m_half = 0;
            else if (m_tick) m_half = 1 - m_half;
            if (!enable || halt) m_phase = 0;
            else m_phase = (m_phase + 1) % 64;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(int'(reset_pulse) == m_rp, "R6", "reset_pulse vs model", int'(reset_pulse), m_rp);
            chk(int'(wake_pulse)  == m_wp, "R8", "wake_pulse vs model",  int'(wake_pulse),  m_wp);
            chk(int'(to_flag)     == m_to, "R2", "to_flag vs model",     int'(to_flag),     m_to);
            chk(int'(pd_flag)     == m_pd, "R7", "pd_flag vs model",     int'(pd_flag),     m_pd);
            if (reset_pulse) rp_seen++;
            if (wake_pulse)  wp_seen++;
        end
    end

    // All tasks start and end just after a falling edge
    task automatic strobe(input bit a, input bit b, input bit h);
        clr_a = a; clr_b = b; halt = h;
        @(negedge clk);
        clr_a = 1'b0; clr_b = 1'b0; halt = 1'b0;
    endtask

    task automatic wait_pulse(input bit want_wake, output int n);
        n = 0;
        do begin
            @(negedge clk);
            clr_a = 1'b0; clr_b = 1'b0; halt = 1'b0;
            n++;
        end while (!(want_wake ? wake_pulse : reset_pulse) && n < 5000);
    endtask

    task automatic restart_div(input logic [2:0] tap);
        enable = 1'b0;
        @(negedge clk);
        tap_sel = tap;
        enable  = 1'b1;
    endtask

    initial begin
        int n, nmin, nmax, rp0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(to_flag == 1'b0 && pd_flag == 1'b0, "R1", "flags after reset", int'({to_flag, pd_flag}), 0);
        chk(reset_pulse == 1'b0 && wake_pulse == 1'b0, "R1", "pulses after reset",
            int'({reset_pulse, wake_pulse}), 0);

        // R9 disabled watchdog stays quiet
        tap_sel = 3'd1;
        repeat (100) @(negedge clk);
        chk(rp_seen + wp_seen == 0, "R9", "pulses while disabled", rp_seen + wp_seen, 0);

        // R9 / R6 first time-out 2P cycles after enable, P=4
        enable = 1'b1;
        wait_pulse(1'b0, n);
        chk(n == 8, "R9", "cycles from enable to time-out", n, 8);
        chk(to_flag == 1'b1, "R6", "to_flag after time-out", int'(to_flag), 1);

        // R3 repeated A and a double strobe do not clear
        enable = 1'b0;
        strobe(1, 0, 0);
        repeat (3) @(negedge clk);
        strobe(1, 0, 0);
        strobe(1, 0, 0);
        chk(to_flag == 1'b1, "R3", "to_flag after repeated A", int'(to_flag), 1);
        strobe(1, 1, 0);
        chk(to_flag == 1'b1, "R3", "to_flag after both strobes together", int'(to_flag), 1);
        repeat (5) @(negedge clk);
        strobe(0, 1, 0);
        chk(to_flag == 1'b0, "R2", "to_flag after A then B", int'(to_flag), 0);

        // R2 reverse order B then A
        restart_div(3'd1);
        wait_pulse(1'b0, n);
        enable = 1'b0;
        strobe(0, 1, 0);
        @(negedge clk);
        chk(to_flag == 1'b1, "R3", "single B leaves to_flag", int'(to_flag), 1);
        strobe(1, 0, 0);
        chk(to_flag == 1'b0, "R2", "to_flag after B then A", int'(to_flag), 0);

        // R5 delay after clear depends on prescaler phase
        restart_div(3'd1);
        wait_pulse(1'b0, n);
        nmin = 1000; nmax = 0;
        for (int k = 0; k < 4; k++) begin
            repeat (k) @(negedge clk);
            strobe(1, 0, 0);
            clr_b = 1'b1;
            wait_pulse(1'b0, n);
            chk(n >= 6 && n <= 9, "R5", "delay from clear to time-out", n, 6);
            if (n < nmin) nmin = n;
            if (n > nmax) nmax = n;
        end
        chk(nmax > nmin, "R5", "delay spread across phases", nmax - nmin, 1);

        // R4 tap selection and clamp
        restart_div(3'd3);
        wait_pulse(1'b0, n);
        chk(n == 32, "R4", "time-out with tap 3", n, 32);
        restart_div(3'd5);
        wait_pulse(1'b0, n);
        chk(n == 128, "R4", "time-out with tap 5", n, 128);
        restart_div(3'd7);
        wait_pulse(1'b0, n);
        chk(n == 128, "R4", "time-out with tap 7 clamped", n, 128);
        restart_div(3'd0);
        wait_pulse(1'b0, n);
        chk(n == 4, "R4", "time-out with tap 0", n, 4);

        // R10 completing strobe on the overflow edge
        enable = 1'b0;
        tap_sel = 3'd1;
        strobe(1, 0, 0);
        enable = 1'b1;
        rp0 = rp_seen;
        repeat (7) @(negedge clk);
        strobe(0, 1, 0);
        chk(reset_pulse == 1'b0 && rp_seen == rp0, "R10", "pulse when clear meets overflow",
            rp_seen - rp0, 0);
        chk(to_flag == 1'b0, "R10", "to_flag when clear meets overflow", int'(to_flag), 0);

        // R7 halt on the overflow edge, then R8 wake pulse
        restart_div(3'd1);
        rp0 = rp_seen;
        repeat (7) @(negedge clk);
        strobe(0, 0, 1);
        chk(rp_seen == rp0 && wake_pulse == 1'b0, "R7", "pulse when halt meets overflow",
            rp_seen - rp0, 0);
        chk(pd_flag == 1'b1 && to_flag == 1'b0, "R7", "flags after halt",
            int'({pd_flag, to_flag}), 2);
        wait_pulse(1'b1, n);
        chk(n == 8, "R8", "halted time-out delay", n, 8);
        chk(rp_seen == rp0, "R8", "no reset pulse while halted", rp_seen - rp0, 0);
        chk(to_flag == 1'b1 && pd_flag == 1'b1, "R8", "flags after wake", int'({to_flag, pd_flag}), 3);
        wait_pulse(1'b0, n);
        chk(n == 8 && reset_pulse == 1'b1, "R8", "next time-out resets", n, 8);

        // R2 completed clear drops pd_flag
        strobe(0, 1, 0);
        strobe(1, 0, 0);
        chk(pd_flag == 1'b0 && to_flag == 1'b0, "R2", "flags after clear following halt",
            int'({pd_flag, to_flag}), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule